// File: doc/BRIEF.md
# Entropy Source Control/Status Registers with Interrupt

This block is the register front end for a hardware random number source. Software writes a control word to switch the generator on and to allow interrupts. It reads a status word that shows whether a random value is waiting and whether the seed stream or the sampling clock is faulty, both as a live view and as a sticky record.

The fault detectors feed the block with level or pulse signals. The data path feeds it with a ready level. The block drives the generator enable and a single registered interrupt line. A sticky fault flag is raised on the same clock edge as its live flag. It stays raised until software writes a zero to it. If a new fault arrives in the same cycle as that zero write, the fault wins. Register reads are captured into a read-data register one edge after the read strobe.

Top module: `entropy_csr`

## Requirements
- R1: After reset the control word, the status word, `gen_enable`, `irq` and `rdata` are all zero.
- R2: A write to byte offset 0x0 stores data bit 3 as interrupt enable and data bit 2 as generator enable. Reading offset 0x0 returns them in the same positions. `gen_enable` follows bit 2 from the write edge onward.
- R3: All control-word bits other than 3 and 2 read as zero. Writes to them, and writes to any offset other than 0x0 and 0x4, change nothing.
- R4: Status word (offset 0x4) bits 2, 1 and 0 show the seed-fault input, the clock-fault input and the data-ready input, each as sampled on the previous clock edge. Writes do not change these bits.
- R5: Status bit 6 (sticky seed fault) and bit 5 (sticky clock fault) are set on the same edge on which live bit 2 or live bit 1, respectively, changes from 0 to 1. They stay set after the live bit falls.
- R6: Writing 0 to status bit 6 or bit 5 clears that sticky flag. Writing 1 to it leaves the flag unchanged.
- R7: When a zero write to a sticky flag and a 0-to-1 change of its live bit fall in the same cycle, the sticky flag ends up set.
- R8: `irq` is a register. On each edge it loads (interrupt enable AND (data-ready bit OR sticky seed flag OR sticky clock flag)), using the values held before that edge. It therefore changes one edge after the flags.
- R9: On an edge with `rd_en` high, `rdata` loads the addressed word; unmapped offsets read as zero. On edges without `rd_en`, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the accessed word |
| wdata | input | DATA_W | Write data |
| seed_fault | input | 1 | Seed-stream fault indication from its detector |
| clk_fault | input | 1 | Sampling-clock fault indication from its detector |
| data_ready | input | 1 | Random value available, from the data path |
| rdata | output | DATA_W | Registered read data |
| gen_enable | output | 1 | Generator enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that a zero write and a fresh fault are the only things that touch a sticky flag, and that the fault inputs are synchronous to `clk`. This holds even when a fault is a one-cycle pulse or is held for many cycles. The stimulus changes every input only on the falling clock edge and holds each strobe for exactly one cycle. It sweeps every control nibble, all eight live-input patterns with interrupts both off and on, and deliberately lines up a clearing write with a fault rising edge. The sticky flags start in both states during that overlap, so the rule that the fault wins is exercised under a stable, legal stimulus.

// File: rtl/entropy_csr_pkg.sv
package entropy_csr_pkg;

  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 4;

  localparam int IE_POS   = 3;
  localparam int EN_POS   = 2;
  localparam int DRDY_POS = 0;

  localparam int NUM_ERR  = 2;   // channel 0: seed stream, channel 1: sampling clock
  localparam int NUM_IRQ_SRC = NUM_ERR + 1;

  function automatic int live_pos(input int ch);
    return (ch == 0) ? 2 : 1;
  endfunction

  function automatic int lat_pos(input int ch);
    return (ch == 0) ? 6 : 5;
  endfunction

endpackage

// File: rtl/entropy_rst_sync.sv
module entropy_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/entropy_ctrl_reg.sv
module entropy_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic ie_d_i,
  input  logic en_d_i,
  output logic ie_o,
  output logic en_o
);
  logic ie_q, en_q;
  logic ie_d, en_d;

  always_comb begin
    ie_d = ie_q;
    en_d = en_q;
    if (wr_i) begin
      ie_d = ie_d_i;
      en_d = en_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      en_q <= 1'b0;
    end else if (wr_i) begin
      ie_q <= ie_d;
      en_q <= en_d;
    end
  end

  assign ie_o = ie_q;
  assign en_o = en_q;

  assert_en_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(en_d_i)));

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(ie_o) && $stable(en_o)));
endmodule

// File: rtl/entropy_err_flag.sv
module entropy_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic clr_i,
  output logic live_o,
  output logic lat_o
);
  logic live_q, lat_q;
  logic live_d, lat_d;
  logic rise;

  always_comb begin
    rise   = fault_i & ~live_q;
    live_d = fault_i;
    if (rise)       lat_d = 1'b1;   // a new fault beats a clearing write
    else if (clr_i) lat_d = 1'b0;
    else            lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      live_q <= live_d;
      lat_q  <= lat_d;
    end
  end

  assign live_o = live_q;
  assign lat_o  = lat_q;

  assert_lat_with_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_o) |-> lat_o);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && fault_i && !live_o) |=> lat_o);

  assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(fault_i && !live_o)) |=> !lat_o);

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && lat_o) |=> lat_o);
endmodule

// File: rtl/entropy_irq.sv
module entropy_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ie_i,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = ie_i & (|src_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |=> !irq_o);

  assert_irq_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_i && (src_i != '0)) |=> irq_o);
endmodule

// File: rtl/entropy_csr.sv
module entropy_csr #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seed_fault,
  input  logic              clk_fault,
  input  logic              data_ready,
  output logic [DATA_W-1:0] rdata,
  output logic              gen_enable,
  output logic              irq
);
  import entropy_csr_pkg::*;

  logic srst_n;
  logic ctrl_sel, stat_sel, ctrl_wr, stat_wr;
  logic ie, en;
  logic drdy_q, drdy_d;
  logic [NUM_ERR-1:0] fault_vec, clr_vec, live_vec, lat_vec;
  logic [DATA_W-1:0] rd_word, rdata_q;
  logic unused_wdata;

  entropy_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    ctrl_sel = (addr == ADDR_W'(CTRL_OFS));
    stat_sel = (addr == ADDR_W'(STAT_OFS));
    ctrl_wr  = wr_en & ctrl_sel;
    stat_wr  = wr_en & stat_sel;
  end

  assign unused_wdata = ^wdata;

  entropy_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_i   (ctrl_wr),
    .ie_d_i (wdata[IE_POS]),
    .en_d_i (wdata[EN_POS]),
    .ie_o   (ie),
    .en_o   (en)
  );

  assign fault_vec = {clk_fault, seed_fault};

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    assign clr_vec[g] = stat_wr & ~wdata[lat_pos(g)];
    entropy_err_flag u_flag (
      .clk     (clk),
      .rst_n   (srst_n),
      .fault_i (fault_vec[g]),
      .clr_i   (clr_vec[g]),
      .live_o  (live_vec[g]),
      .lat_o   (lat_vec[g])
    );
  end

  always_comb drdy_d = data_ready;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) drdy_q <= 1'b0;
    else         drdy_q <= drdy_d;
  end

  entropy_irq #(.NSRC(NUM_IRQ_SRC)) u_irq (
    .clk   (clk),
    .rst_n (srst_n),
    .ie_i  (ie),
    .src_i ({lat_vec, drdy_q}),
    .irq_o (irq)
  );

  always_comb begin
    rd_word = '0;
    if (ctrl_sel) begin
      rd_word[IE_POS] = ie;
      rd_word[EN_POS] = en;
    end else if (stat_sel) begin
      rd_word[DRDY_POS] = drdy_q;
      for (int c = 0; c < NUM_ERR; c++) begin
        rd_word[live_pos(c)] = live_vec[c];
        rd_word[lat_pos(c)]  = lat_vec[c];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata      = rdata_q;
  assign gen_enable = en;

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> $stable(rdata));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !ctrl_sel && !stat_sel) |=> (rdata == '0));
endmodule

// File: tb/entropy_csr_tb.sv
module entropy_csr_tb;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic seed_fault, clk_fault, data_ready;
  logic [DW-1:0] rdata;
  logic gen_enable, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  entropy_csr #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .seed_fault (seed_fault),
    .clk_fault (clk_fault), .data_ready (data_ready),
    .rdata (rdata), .gen_enable (gen_enable), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd, held;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    seed_fault = 1'b0; clk_fault = 1'b0; data_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 gen_enable", {31'b0, gen_enable}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    do_read(4'h0, rd); chk("R1 ctrl", rd, 32'h0);
    do_read(4'h4, rd); chk("R1 status", rd, 32'h0);

    // R2/R3: sweep every low nibble with reserved bits set
    for (int v = 0; v < 16; v++) begin
      do_write(4'h0, 32'hFFFF_FFF0 | v);
      chk("R2 gen_enable", {31'b0, gen_enable}, (v >> 2) & 1);
      do_read(4'h0, rd);
      chk("R2/R3 ctrl readback", rd, v & 32'hC);
    end

    // R3: unmapped offsets ignore writes and read zero
    do_write(4'h0, 32'h0);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) begin
        do_write(AW'(a), 32'hFFFF_FFFF);
        do_read(AW'(a), rd); chk("R3/R9 unmapped read", rd, 32'h0);
      end
    end
    do_read(4'h0, rd); chk("R3 ctrl after unmapped writes", rd, 32'h0);
    chk("R3 gen_enable", {31'b0, gen_enable}, 32'h0);

    // R4/R5/R6: all live patterns {seed,clk,drdy}
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      seed_fault = v[2]; clk_fault = v[1]; data_ready = v[0];
      do_read(4'h4, rd);
      chk("R4/R5 live and sticky", rd, v | ((v >> 2) & 1) << 6 | ((v >> 1) & 1) << 5);
      @(negedge clk);
      seed_fault = 1'b0; clk_fault = 1'b0; data_ready = 1'b0;
      do_read(4'h4, rd);
      chk("R5 sticky after live falls", rd, (((v >> 2) & 1) << 6) | (((v >> 1) & 1) << 5));
      do_write(4'h4, 32'hFFFF_FFFF);
      do_read(4'h4, rd);
      chk("R4/R6 write one keeps flags", rd, (((v >> 2) & 1) << 6) | (((v >> 1) & 1) << 5));
      do_write(4'h4, 32'h0);
      do_read(4'h4, rd);
      chk("R6 write zero clears", rd, 32'h0);
    end

    // R7: clear and fault rise in the same cycle (seed sticky already set, clock not)
    @(negedge clk); seed_fault = 1'b1;
    @(negedge clk); seed_fault = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h4; wdata = 32'h0; seed_fault = 1'b1; clk_fault = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; seed_fault = 1'b0; clk_fault = 1'b0;
    do_read(4'h4, rd);
    chk("R7 set wins over clear", rd, 32'h60);
    do_write(4'h4, 32'h0);
    do_read(4'h4, rd); chk("R6 clear after R7", rd, 32'h0);

    // R8: interrupt with enable off, then on, for every source pattern
    for (int ie = 0; ie < 2; ie++) begin
      do_write(4'h0, ie ? 32'h8 : 32'h0);
      for (int v = 0; v < 8; v++) begin
        @(negedge clk); @(negedge clk);
        seed_fault = v[2]; clk_fault = v[1]; data_ready = v[0];
        @(negedge clk);
        chk("R8 irq one edge late", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq value", {31'b0, irq}, (ie != 0 && v != 0) ? 32'h1 : 32'h0);
        seed_fault = 1'b0; clk_fault = 1'b0; data_ready = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R8 irq from sticky only", {31'b0, irq}, (ie != 0 && (v & 6) != 0) ? 32'h1 : 32'h0);
        do_write(4'h4, 32'h0);
        @(negedge clk);
        chk("R8 irq after clear", {31'b0, irq}, 32'h0);
      end
    end

    // R8: masking a pending source drops irq after one edge
    @(negedge clk); data_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 irq pending", {31'b0, irq}, 32'h1);
    do_write(4'h0, 32'h0);
    @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);

    // R9: rdata holds without rd_en
    do_read(4'h4, held);
    chk("R9 read drdy", held, 32'h1);
    @(negedge clk); data_ready = 1'b0; seed_fault = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 rdata held", rdata, held);
    seed_fault = 1'b0;
    do_read(4'h4, rd);
    chk("R9 fresh read", rd, 32'h40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule